// File: doc/BRIEF.md
# Operation-Select Arithmetic Unit

This block is a purely combinational arithmetic unit. It takes two unsigned 8-bit operands and a 2-bit operation code and drives a single 16-bit result bus that all operations share. The code picks one of three functions: an unsigned magnitude comparison, an 8-bit addition, or an 8-by-8 multiplication. The fourth code drives the bus to zero.

None of the three functions uses an arithmetic or relational operator. The comparator scans the operand bits from the most significant end with XOR/AND/OR logic. The adder joins 4-bit slices. Each slice forms propagate and generate terms and computes every carry inside the slice in parallel, and the carry ripples from one slice to the next. The multiplier is an array of AND-gate partial-product rows. These rows are reduced with full adders in carry-save form and finished by a ripple row of full adders.

There is no clock and no state. The result follows the inputs after the gate delay. A host samples it wherever its own timing allows.

Top module: `osau`

## Requirements
- R1: With op_sel = 2'b00 the operands are compared as unsigned numbers. result[0] is 1 when op_a > op_b, result[1] is 1 when op_a = op_b, and result[2] is 1 when op_a < op_b. result[15:3] is zero.
- R2: With op_sel = 2'b01, result[8:0] is the 9-bit unsigned sum op_a + op_b with a carry-in of zero, where result[8] is the carry out. result[15:9] is zero.
- R3: With op_sel = 2'b10, result[15:0] is the unsigned 16-bit product op_a * op_b.
- R4: With op_sel = 2'b11, result is all zeros whatever the operands.
- R5: In compare mode exactly one of result[2:0] is set for every operand pair.
- R6: The result depends only on the present inputs. A change of operands or op_sel shows on result with no clock edge in between.
- R7: In add mode a carry out of bit 3 reaches the upper 4-bit slice, and a carry out of bit 7 appears on result[8]. For example, 8'h0F + 8'h01 = 9'h010 and 8'hFF + 8'hFF = 9'h1FE.
- R8: In multiply mode a zero operand on either side gives a zero result, and 8'hFF * 8'hFF gives 16'hFE01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 8 | First operand, unsigned |
| op_b | input | 8 | Second operand, unsigned |
| op_sel | input | 2 | Operation code: 00 compare, 01 add, 10 multiply, 11 zero |
| result | output | 16 | Shared result bus |

## Verification
The assertions assume that operands and op_sel carry known 0/1 values whenever they are evaluated. They also assume that result is read only after the combinational logic has settled for the present inputs. The bench keeps to this. It drives every input from a procedural block, holds each vector steady, waits one time step before sampling, and never applies an unknown value. It sweeps every operand pair for all four codes exhaustively, runs directed corner vectors (zero, all ones, equal operands, carries at slice boundaries), and finishes with random pairs.

// File: rtl/osau_pkg.sv
package osau_pkg;
  typedef enum logic [1:0] {
    OP_CMP  = 2'b00,
    OP_ADD  = 2'b01,
    OP_MUL  = 2'b10,
    OP_ZERO = 2'b11
  } op_e;
endpackage

// File: rtl/osau_fa.sv
// Single-bit full adder used by the multiplier array.
module osau_fa (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);
  assign s  = x ^ y ^ ci;
  assign co = (x & y) | (x & ci) | (y & ci);
endmodule

// File: rtl/osau_cla.sv
// Lookahead slice: every internal carry formed in parallel from p/g terms.
module osau_cla #(
  parameter int SW = 4
) (
  input  logic [SW-1:0] a,
  input  logic [SW-1:0] b,
  input  logic          ci,
  output logic [SW-1:0] s,
  output logic          co
);
  logic [SW-1:0] prop;
  logic [SW-1:0] gen;
  logic [SW:0]   cy;

  assign prop = a ^ b;
  assign gen  = a & b;

  always_comb begin
    logic term;
    cy[0] = ci;
    for (int i = 1; i <= SW; i++) begin
      cy[i] = 1'b0;
      for (int j = 0; j < i; j++) begin
        term = gen[j];
        for (int k = j + 1; k < i; k++) term = term & prop[k];
        cy[i] = cy[i] | term;
      end
      term = ci;
      for (int k = 0; k < i; k++) term = term & prop[k];
      cy[i] = cy[i] | term;
    end
  end

  assign s  = prop ^ cy[SW-1:0];
  assign co = cy[SW];
endmodule

// File: rtl/osau_add.sv
// Adder built from lookahead slices; the carry ripples between slices.
module osau_add #(
  parameter int W  = 8,
  parameter int SW = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         ci,
  output logic [W-1:0] sum,
  output logic         co
);
  localparam int NS = W / SW;
  logic [NS:0] link;

  assign link[0] = ci;

  for (genvar g = 0; g < NS; g++) begin : g_slice
    osau_cla #(.SW(SW)) u_cla (
      .a  (a[g*SW +: SW]),
      .b  (b[g*SW +: SW]),
      .ci (link[g]),
      .s  (sum[g*SW +: SW]),
      .co (link[g+1])
    );
  end

  assign co = link[NS];
endmodule

// File: rtl/osau_cmp.sv
// Unsigned magnitude compare from bit gates, scanned from the MSB.
module osau_cmp #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         gt,
  output logic         eq,
  output logic         lt
);
  always_comb begin
    logic same;
    same = 1'b1;
    gt   = 1'b0;
    lt   = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      gt   = gt | (same & a[i] & ~b[i]);
      lt   = lt | (same & ~a[i] & b[i]);
      same = same & ~(a[i] ^ b[i]);
    end
    eq = same;
  end
endmodule

// File: rtl/osau_mult.sv
// Array multiplier: AND rows, carry-save full-adder rows, final ripple row.
module osau_mult #(
  parameter int N = 8
) (
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic [2*N-1:0] p
);
  localparam int RW = N - 1;

  logic [RW-1:0] s_row [N];
  logic [RW-1:0] c_row [N];
  logic [RW:0]   rip;

  // first row: partial products only, no carries yet
  assign p[0]     = a[0] & b[0];
  assign c_row[0] = '0;
  for (genvar k = 0; k < RW; k++) begin : g_top
    assign s_row[0][k] = a[0] & b[k+1];
  end

  // carry-save rows
  for (genvar i = 1; i < N; i++) begin : g_row
    logic [N-1:0]  pp;
    logic [RW-1:0] fs;
    assign pp              = {N{a[i]}} & b;
    assign s_row[i][RW-1]  = pp[N-1];
    assign p[i]            = fs[0];
    for (genvar k = 0; k < RW; k++) begin : g_cell
      osau_fa u_fa (
        .x  (s_row[i-1][k]),
        .y  (c_row[i-1][k]),
        .ci (pp[k]),
        .s  (fs[k]),
        .co (c_row[i][k])
      );
      if (k > 0) begin : g_pass
        assign s_row[i][k-1] = fs[k];
      end
    end
  end

  // final ripple row makes the upper half
  assign rip[0] = 1'b0;
  for (genvar k = 0; k < RW; k++) begin : g_low
    osau_fa u_fa (
      .x  (s_row[N-1][k]),
      .y  (c_row[N-1][k]),
      .ci (rip[k]),
      .s  (p[N+k]),
      .co (rip[k+1])
    );
  end
  assign p[2*N-1] = rip[RW];
endmodule

// File: rtl/osau.sv
module osau #(
  parameter int DW = 8,
  parameter int SW = 4
) (
  input  logic [DW-1:0]   op_a,
  input  logic [DW-1:0]   op_b,
  input  logic [1:0]      op_sel,
  output logic [2*DW-1:0] result
);
  import osau_pkg::*;

  localparam int RW = 2 * DW;

  logic          gt, eq, lt;
  logic [DW-1:0] add_sum;
  logic          add_co;
  logic [RW-1:0] prod;
  op_e           op;

  osau_cmp #(.W(DW)) u_cmp (
    .a (op_a), .b (op_b), .gt (gt), .eq (eq), .lt (lt)
  );

  osau_add #(.W(DW), .SW(SW)) u_add (
    .a (op_a), .b (op_b), .ci (1'b0), .sum (add_sum), .co (add_co)
  );

  osau_mult #(.N(DW)) u_mult (
    .a (op_a), .b (op_b), .p (prod)
  );

  assign op = op_e'(op_sel);

  always_comb begin
    case (op)
      OP_CMP:  result = {{(RW-3){1'b0}}, lt, eq, gt};
      OP_ADD:  result = {{(RW-DW-1){1'b0}}, add_co, add_sum};
      OP_MUL:  result = prod;
      default: result = '0;
    endcase
  end
endmodule

// File: rtl/osau_chk.sv
module osau_chk #(
  parameter int DW = 8
) (
  input logic [DW-1:0]   op_a,
  input logic [DW-1:0]   op_b,
  input logic [1:0]      op_sel,
  input logic [2*DW-1:0] result
);
  always_comb begin
    if (op_sel == 2'b00) begin
      // R1
      cmp_upper_zero_chk: assert (result[2*DW-1:3] == '0)
        else $error("compare upper bits not zero");
      // R5
      cmp_onehot_chk: assert ($countones(result[2:0]) == 1)
        else $error("compare flags not one-hot");
      // R1
      cmp_equal_chk: assert (!(op_a == op_b) || result == 2)
        else $error("equal operands not flagged");
    end
    if (op_sel == 2'b01) begin
      // R2
      add_upper_zero_chk: assert (result[2*DW-1:DW+1] == '0)
        else $error("add upper bits not zero");
    end
    if (op_sel == 2'b10) begin
      // R8
      mul_zero_chk: assert (!(op_a == '0 || op_b == '0) || result == '0)
        else $error("zero operand product not zero");
      // R3
      mul_unit_chk: assert (!(op_b == 1) || result == {{DW{1'b0}}, op_a})
        else $error("product by one wrong");
    end
    if (op_sel == 2'b11) begin
      // R4
      idle_zero_chk: assert (result == '0)
        else $error("unused code not zero");
    end
  end
endmodule

bind osau osau_chk #(.DW(DW)) u_chk (
  .op_a   (op_a),
  .op_b   (op_b),
  .op_sel (op_sel),
  .result (result)
);

// File: tb/osau_bench.sv
`timescale 1ns/1ps
module osau_bench;
  logic        clk;
  logic [7:0]  op_a;
  logic [7:0]  op_b;
  logic [1:0]  op_sel;
  logic [15:0] result;
  int checks;
  int failures;
  bit done;

  osau u_osau (.op_a(op_a), .op_b(op_b), .op_sel(op_sel), .result(result));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [15:0] model(logic [1:0] s, logic [7:0] a, logic [7:0] b);
    case (s)
      2'b00: model = {13'd0, a < b, a == b, a > b};
      2'b01: model = {7'd0, {1'b0, a} + {1'b0, b}};
      2'b10: model = 16'(a) * 16'(b);
      default: model = 16'd0;
    endcase
  endfunction

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s a=%h b=%h sel=%b got=%h exp=%h", req, op_a, op_b, op_sel, got, exp);
    end
  endtask

  task automatic apply(logic [1:0] s, logic [7:0] a, logic [7:0] b);
    op_sel = s; op_a = a; op_b = b;
    #1;
  endtask

  task automatic t_start;
    apply(2'b00, 8'h00, 8'h00);
    chk("R1", result, 16'h0002);
  endtask

  task automatic t_compare;
    apply(2'b00, 8'h80, 8'h7F); chk("R1", result, 16'h0001);
    apply(2'b00, 8'h7F, 8'h80); chk("R1", result, 16'h0004);
    apply(2'b00, 8'hFF, 8'hFF); chk("R5", result, 16'h0002);
    apply(2'b00, 8'h00, 8'hFF); chk("R5", result, 16'h0004);
  endtask

  task automatic t_add;
    apply(2'b01, 8'h0F, 8'h01); chk("R7", result, 16'h0010);
    apply(2'b01, 8'hFF, 8'hFF); chk("R7", result, 16'h01FE);
    apply(2'b01, 8'hFF, 8'h01); chk("R7", result, 16'h0100);
    apply(2'b01, 8'h12, 8'h34); chk("R2", result, 16'h0046);
  endtask

  task automatic t_mul;
    apply(2'b10, 8'hFF, 8'hFF); chk("R8", result, 16'hFE01);
    apply(2'b10, 8'h00, 8'hA5); chk("R8", result, 16'h0000);
    apply(2'b10, 8'h5A, 8'h00); chk("R8", result, 16'h0000);
    apply(2'b10, 8'h80, 8'h02); chk("R3", result, 16'h0100);
    apply(2'b10, 8'h0D, 8'h0B); chk("R3", result, 16'h008F);
  endtask

  task automatic t_zero_code;
    apply(2'b11, 8'hFF, 8'hFF); chk("R4", result, 16'h0000);
    apply(2'b11, 8'h3C, 8'hC3); chk("R4", result, 16'h0000);
  endtask

  task automatic t_no_clock;
    // inputs change between clock edges; result must follow at once
    @(posedge clk); #0.5;
    apply(2'b10, 8'h10, 8'h10); chk("R6", result, 16'h0100);
    apply(2'b01, 8'h10, 8'h10); chk("R6", result, 16'h0020);
  endtask

  task automatic t_sweep;
    for (int s = 0; s < 4; s++)
      for (int a = 0; a < 256; a++)
        for (int b = 0; b < 256; b++) begin
          apply(2'(s), 8'(a), 8'(b));
          case (s)
            0: chk("R1", result, model(2'(s), 8'(a), 8'(b)));
            1: chk("R2", result, model(2'(s), 8'(a), 8'(b)));
            2: chk("R3", result, model(2'(s), 8'(a), 8'(b)));
            default: chk("R4", result, model(2'(s), 8'(a), 8'(b)));
          endcase
        end
  endtask

  task automatic t_random;
    for (int n = 0; n < 2000; n++) begin
      logic [1:0] s;
      logic [7:0] a, b;
      s = 2'($urandom_range(0, 3));
      a = 8'($urandom);
      b = 8'($urandom);
      apply(s, a, b);
      chk("R3", result, model(s, a, b));
    end
  endtask

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    t_start;
    t_compare;
    t_add;
    t_mul;
    t_zero_code;
    t_no_clock;
    t_sweep;
    t_random;
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule